// File: doc/BRIEF.md
# 8-bit timer PWM generator

This block is an up-counting 8-bit timer that produces a pulse-width-modulated waveform on a single output. The count clock is derived from the input clock through a binary prescaler with eight selectable ratios. The counter runs freely and wraps from 255 to 0. Each wrap opens the active part of the period, and the counter reaching the compare value closes it. The duty is therefore the compare value over 256.

Software writes the compare value into a holding register. The holding register is moved into the working compare register only at a wrap, so a period is never cut by a mid-period update. Run, mode, output enable, polarity and prescaler select are level inputs from the control register. Immediately after start, the output stays at its inactive level for one full counter revolution before the first active phase.

Top module: `pwm_timer8`

## Requirements
- R1: While reset is asserted and after it is released, the output shows the inactive level, which is the complement of `act_high_i`. The holding and working compare registers reset to 0.
- R2: With prescaler code k on `clk_sel_i`, the counter advances once every 2^(k+1) clocks. The first advance comes on the 2^(k+1)-th clock edge that samples `run_i` = 1. One output period lasts 256 * 2^(k+1) clocks.
- R3: After `run_i` rises, the output stays inactive until the first wrap from 255 to 0. That wrap happens on clock edge 256 * 2^(k+1) counted from the first edge that samples `run_i` = 1. The output becomes active right after that edge.
- R4: In every period, the output is active for exactly C * 2^(k+1) clocks after the wrap, where C is the working compare value. It is inactive for the rest of the period.
- R5: A compare write (`cmp_wr_i` = 1 for one clock) changes only the holding register. The working value is updated from the holding register at the next wrap. A write in the same clock as a wrap takes effect at the following wrap. With several writes in one period, the last one wins.
- R6: `act_high_i` = 1 makes the active level 1 and the inactive level 0. `act_high_i` = 0 swaps them. Both take effect on the output in the same clock.
- R7: With `out_en_i` = 0, the output holds the inactive level. The waveform keeps running internally, and re-enabling shows the current phase in the same clock.
- R8: With `pwm_mode_i` = 0, the output stays inactive for the whole time. When the mode bit returns to 1 in mid-period, the output stays inactive until the next wrap.
- R9: One clock after `run_i` is sampled 0, the output is inactive and the counter and prescaler are cleared. A restart again begins with a full inactive revolution.
- R10: C = 0 gives an output that is never active. C = 255 gives an output that is active for 255 counts and inactive for one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Count enable; 0 stops and clears the timer |
| pwm_mode_i | input | 1 | 1 selects PWM waveform generation |
| out_en_i | input | 1 | 1 lets the waveform reach the output |
| act_high_i | input | 1 | Active level of the output |
| clk_sel_i | input | 3 | Prescaler code k, ratio 2^(k+1) |
| cmp_wr_i | input | 1 | Write strobe for the compare holding register |
| cmp_data_i | input | 8 | Compare value to write |
| pwm_o | output | 1 | PWM output |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a compare write and a counter wrap. The bench tracks the edge count since start and places a write exactly on the wrap edge. It then expects the old holding value for the coming period and the new value one period later. The second pair is the wrap and the compare match when C = 0: the active phase would open and close on the same edge, so the bench expects no active sample at all. A C = 255 run places the match one count before the wrap, and the bench checks the single inactive count between them.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;

  typedef struct packed {
    logic run;
    logic pwm_mode;
    logic out_en;
    logic act_high;
  } pwm_ctrl_t;

  function automatic logic drive_level(input logic active, input logic act_high);
    return active ? act_high : ~act_high;
  endfunction

endpackage

// File: rtl/pwm_timer8_rst_sync.sv
module pwm_timer8_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/pwm_timer8_presc.sv
module pwm_timer8_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int PRE_W = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] span_mask;

  // Bit b takes part in the terminal test when b <= selected code
  for (genvar b = 0; b < PRE_W; b++) begin : g_mask
    assign span_mask[b] = (SEL_W'(b) <= sel_i);
  end

  always_comb begin
    if (!run_i) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  assign tick_o = run_i && ((pre_q & span_mask) == span_mask);

endmodule

// File: rtl/pwm_timer8_count.sv
module pwm_timer8_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  output logic             wrap_o,
  output logic             end_o,
  output logic             load_nz_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic [CNT_W-1:0] cmp_buf_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] buf_q,  buf_d;
  logic             buf_en;
  logic [CNT_W-1:0] act_q,  act_d;
  logic             act_en;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  // counter: cleared while stopped, advanced on each prescaler tick
  always_comb begin
    cnt_en = tick_i || !run_i;
    cnt_d  = run_i ? cnt_inc : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign wrap_o = tick_i && (cnt_q == CNT_TOP);
  assign end_o  = tick_i && !wrap_o && (cnt_inc == act_q);

  // holding register: written by software at any time
  always_comb begin
    buf_en = cmp_wr_i;
    buf_d  = cmp_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
    end
  end

  // working register: loaded from the holding register on a wrap only
  always_comb begin
    act_en = wrap_o;
    act_d  = buf_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign load_nz_o = (buf_q != '0);
  assign cnt_o     = cnt_q;
  assign cmp_act_o = act_q;
  assign cmp_buf_o = buf_q;

endmodule

// File: rtl/pwm_timer8_wave.sv
module pwm_timer8_wave
  import pwm_timer8_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwm_ctrl_t ctrl_i,
  input  logic      wrap_i,
  input  logic      end_i,
  input  logic      load_nz_i,
  output logic      phase_o,
  output logic      pin_o
);

  logic phase_q, phase_d;

  always_comb begin
    if (!ctrl_i.run || !ctrl_i.pwm_mode) begin
      phase_d = 1'b0;
    end else if (wrap_i) begin
      phase_d = load_nz_i;
    end else if (end_i) begin
      phase_d = 1'b0;
    end else begin
      phase_d = phase_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;
  assign pin_o   = drive_level(phase_q && ctrl_i.out_en, ctrl_i.act_high);

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pwm_mode_i,
  input  logic             out_en_i,
  input  logic             act_high_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  output logic             pwm_o
);

  logic             rst_n_s;
  logic             tick;
  logic             wrap;
  logic             cmp_end;
  logic             load_nz;
  logic             phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] cmp_buf;
  pwm_ctrl_t        ctrl;

  assign ctrl = '{run: run_i, pwm_mode: pwm_mode_i,
                  out_en: out_en_i, act_high: act_high_i};

  pwm_timer8_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  pwm_timer8_presc #(.SEL_W(SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (run_i),
    .sel_i  (clk_sel_i),
    .tick_o (tick)
  );

  pwm_timer8_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .run_i      (run_i),
    .tick_i     (tick),
    .cmp_wr_i   (cmp_wr_i),
    .cmp_data_i (cmp_data_i),
    .wrap_o     (wrap),
    .end_o      (cmp_end),
    .load_nz_o  (load_nz),
    .cnt_o      (cnt),
    .cmp_act_o  (cmp_act),
    .cmp_buf_o  (cmp_buf)
  );

  pwm_timer8_wave u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .ctrl_i    (ctrl),
    .wrap_i    (wrap),
    .end_i     (cmp_end),
    .load_nz_i (load_nz),
    .phase_o   (phase),
    .pin_o     (pwm_o)
  );

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             pwm_mode_i,
  input logic             act_high_i,
  input logic             pwm_o,
  input logic             tick,
  input logic             wrap,
  input logic             phase,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_act,
  input logic [CNT_W-1:0] cmp_buf
);

  p_tick_needs_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> run_i);

  p_hold_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick) |=> $stable(cnt));

  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (cnt == '0));

  p_wrap_opens_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && pwm_mode_i && (cmp_buf != '0)) |=> phase);

  p_active_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase |-> (cnt < cmp_act));

  p_cmp_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(cmp_act));

  p_mode_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_mode_i |=> (pwm_o == ~act_high_i));

  p_stop_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ((cnt == '0) && (pwm_o == ~act_high_i)));

endmodule

bind pwm_timer8 pwm_timer8_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .pwm_mode_i (pwm_mode_i),
  .act_high_i (act_high_i),
  .pwm_o      (pwm_o),
  .tick       (tick),
  .wrap       (wrap),
  .phase      (phase),
  .cnt        (cnt),
  .cmp_act    (cmp_act),
  .cmp_buf    (cmp_buf)
);

// File: tb/pwm_timer8_tb_top.sv
`timescale 1ns/1ps
module pwm_timer8_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run, mode, oe, ah, wr;
  logic [2:0] sel;
  logic [7:0] wd;
  logic       pin;

  always #4 clk = ~clk;

  pwm_timer8 dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .run_i      (run),
    .pwm_mode_i (mode),
    .out_en_i   (oe),
    .act_high_i (ah),
    .clk_sel_i  (sel),
    .cmp_wr_i   (wr),
    .cmp_data_i (wd),
    .pwm_o      (pin)
  );

  int n_chk = 0;
  int n_fail = 0;
  // arithmetic reference state
  int n_ed = 0;
  int c_buf = 0;
  int c_cur = 0;
  bit ph_m = 0;
  int win_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    int dv;
    int cv;
    @(posedge clk);
    if (!run) begin
      n_ed = 0;
      ph_m = 0;
    end else begin
      n_ed++;
      dv = 2 << int'(sel);
      if (n_ed % dv == 0) begin
        cv = (n_ed / dv) % 256;
        if (cv == 0) begin
          c_cur = c_buf;
          ph_m  = mode && (c_cur != 0);
        end else if (cv == c_cur) begin
          ph_m = 0;
        end
      end
      if (!mode) ph_m = 0;
    end
    if (wr) c_buf = int'(wd);
    @(negedge clk);
    if (pin !== ((ph_m && oe) ? ah : !ah)) win_err++;
  endtask

  task automatic steps(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic wr_cmp(input int v);
    wr = 1'b1;
    wd = 8'(v);
    step();
    wr = 1'b0;
  endtask

  task automatic win_close(input string req, input string what);
    check(win_err == 0, req, what, win_err, 0);
    win_err = 0;
  endtask

  // len steps, counting active samples; optional writes at wj/wj2
  task automatic period(input int len, input int wj, input int wv,
                        input int wj2, input int wv2, output int a);
    a = 0;
    for (int j = 0; j < len; j++) begin
      wr = (j == wj) || (j == wj2);
      wd = (j == wj2) ? 8'(wv2) : 8'(wv);
      step();
      if (pin === ah) a++;
    end
    wr = 1'b0;
  endtask

  initial begin
    int cnt, w, g, a, dv;
    rst_n = 1'b0; run = 1'b0; mode = 1'b1; oe = 1'b1; ah = 1'b1;
    sel = 3'd0; wr = 1'b0; wd = 8'd0;
    repeat (5) @(negedge clk);
    check(pin === 1'b0, "R1", "pin in reset, active high", int'(pin), 0);
    ah = 1'b0;
    #1;
    check(pin === 1'b1, "R1", "pin in reset, active low", int'(pin), 1);
    ah = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    steps(4);
    check(pin === 1'b0, "R1", "pin after reset", int'(pin), 0);

    // R2 R3 R4 R9: prescaler sweep with compare 4
    for (int k = 0; k < 8; k++) begin
      if (k != 6) begin
        sel = 3'(k);
        dv = 2 << k;
        wr_cmp(4);
        run = 1'b1;
        cnt = 0;
        do begin
          step();
          cnt++;
        end while (pin !== ah && cnt < 70000);
        check(cnt == 256 * dv, "R3", $sformatf("first active, code %0d", k), cnt, 256 * dv);
        w = 1;
        do begin
          step();
          if (pin === ah) w++;
        end while (pin === ah && w < 2000);
        check(w == 4 * dv, "R4", $sformatf("active width, code %0d", k), w, 4 * dv);
        if (k <= 5) begin
          g = 1;
          do begin
            step();
            if (pin !== ah) g++;
          end while (pin !== ah && g < 20000);
          check(g == 252 * dv, "R2", $sformatf("inactive gap, code %0d", k), g, 252 * dv);
        end
        run = 1'b0;
        step();
        check(pin === 1'b0, "R9", $sformatf("stop, code %0d", k), int'(pin), 0);
      end
    end
    win_close("R2", "sample trace over prescaler sweep");

    // R4: many compare values, writes at scattered offsets
    sel = 3'd0;
    run = 1'b1;
    for (int i = 0; i < 32; i++) begin
      int v;
      v = (i % 8 == 0) ? 0 : (i % 8 == 1) ? 255 : (i % 8 == 2) ? 1 : (i * 53 + 7) % 256;
      period(512, (i * 37) % 512, v, -1, 0, a);
    end
    win_close("R4", "sample trace over compare sweep");
    run = 1'b0;
    step();

    // R10: extremes 255 then 0
    wr_cmp(255);
    run = 1'b1;
    period(511, -1, 0, -1, 0, a);
    check(a == 0, "R10", "first revolution with 255", a, 0);
    period(512, 100, 0, -1, 0, a);
    check(a == 510, "R10", "active samples with 255", a, 510);
    period(512, -1, 0, -1, 0, a);
    check(a == 0, "R10", "active samples with 0", a, 0);
    win_close("R10", "sample trace at extremes");
    run = 1'b0;
    step();

    // R5: buffering, double write, write on the wrap edge
    wr_cmp(10);
    run = 1'b1;
    steps(511);
    period(512, 8, 200, -1, 0, a);
    check(a == 20, "R5", "write during active phase deferred", a, 20);
    period(512, 100, 30, 300, 77, a);
    check(a == 400, "R5", "value after deferred write", a, 400);
    period(512, -1, 0, -1, 0, a);
    check(a == 154, "R5", "last of two writes wins", a, 154);
    period(512, 0, 90, -1, 0, a);
    check(a == 154, "R5", "write on wrap edge not used yet", a, 154);
    period(512, -1, 0, -1, 0, a);
    check(a == 180, "R5", "write on wrap edge used next period", a, 180);
    win_close("R5", "sample trace over buffering");
    run = 1'b0;
    step();

    // R6: active-low polarity
    ah = 1'b0;
    wr_cmp(50);
    check(pin === 1'b1, "R6", "inactive level high when stopped", int'(pin), 1);
    run = 1'b1;
    period(511, -1, 0, -1, 0, a);
    check(a == 0, "R6", "no low sample before first wrap", a, 0);
    period(512, -1, 0, -1, 0, a);
    check(a == 100, "R6", "low samples per period", a, 100);
    win_close("R6", "sample trace active low");
    run = 1'b0;
    step();
    ah = 1'b1;

    // R7: output enable gating mid-phase
    wr_cmp(100);
    run = 1'b1;
    steps(511);
    a = 0;
    for (int j = 0; j < 512; j++) begin
      if (j == 50) oe = 1'b0;
      if (j == 150) oe = 1'b1;
      step();
      if (j == 150) check(pin === 1'b1, "R7", "phase visible on re-enable", int'(pin), 1);
      if (pin === ah) a++;
    end
    check(a == 100, "R7", "active samples with gap", a, 100);
    win_close("R7", "sample trace with gating");

    // R8: mode bit off, then on mid-period
    mode = 1'b0;
    period(512, -1, 0, -1, 0, a);
    check(a == 0, "R8", "mode off whole period", a, 0);
    a = 0;
    for (int j = 0; j < 512; j++) begin
      if (j == 20) mode = 1'b1;
      step();
      if (pin === ah) a++;
    end
    check(a == 0, "R8", "mode back on mid-period", a, 0);
    period(512, -1, 0, -1, 0, a);
    check(a == 200, "R8", "period after mode restored", a, 200);
    win_close("R8", "sample trace over mode change");

    // R9: stop in active phase and restart
    steps(30);
    check(pin === 1'b1, "R9", "active before stop", int'(pin), 1);
    run = 1'b0;
    step();
    check(pin === 1'b0, "R9", "inactive after stop", int'(pin), 0);
    run = 1'b1;
    period(511, -1, 0, -1, 0, a);
    check(a == 0, "R9", "restart first revolution", a, 0);
    period(512, -1, 0, -1, 0, a);
    check(a == 200, "R9", "restart first period", a, 200);
    win_close("R9", "sample trace over restart");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule